// File: doc/BRIEF.md
# Stripe Parity Engine

This block computes the redundancy word stream for a striped disk array with four data members and one parity member per stripe. A command selects one of three operations and a block length in words. The block then consumes one word from every input lane in the same cycle, XORs the selected lanes, and emits one result word per consumed word.

- A full-stripe write takes the four data blocks on the lanes and produces the parity block.
- A small write takes only new data, old data and old parity, and produces the new parity.
- A rebuild takes the four surviving members of a stripe and produces the missing one.

Beside the streaming path, a combinational lookup reports where the parity and data blocks of a stripe sit when parity rotates from stripe to stripe.

The result stream applies backpressure to the input lanes. Its final word carries a last flag, and a done pulse marks the end of the operation. While an operation runs, the block ignores further commands.

Top module: `parity_engine`

## Requirements
- R1: Operation code 0 (full-stripe write) produces, for each consumed word, the XOR of the words on all four lanes, where lane i occupies bits [32*i+31 : 32*i] of the input bus.
- R2: Operation code 1 (small write) produces lane0 XOR lane1 XOR lane2, with lane0 carrying the new data, lane1 the old data and lane2 the old parity. Lane 3 has no effect on the result.
- R3: Operation code 2 (rebuild) produces the XOR of all four lanes, which carry the three surviving data blocks and the parity block.
- R4: A word is taken from every lane at once on a cycle where both the lane valid and the lane ready signals are high. An accepted command of length L yields exactly L taken words and L result words. Ready is only high while busy.
- R5: While a result word is valid and not accepted downstream, the result data and last flag stay unchanged in the next cycle.
- R6: The last flag is high on the L-th result word and on no earlier word of the operation.
- R7: Done is high for exactly the one cycle after the final result word is accepted. Busy is high from the cycle after a command is accepted through that done cycle, and low in the cycle after it.
- R8: A command presented while busy is ignored: the running operation keeps its operation code and length.
- R9: A command with operation code 3 or with length 0 is ignored, and busy stays low.
- R10: For stripe number s, the parity member index is 4 - (s mod 5).
- R11: Data block d (0 to 3) of stripe s sits on member d when d is below the parity member, and on member d+1 otherwise.
- R12: After reset, busy, done, result valid and lane ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | Operation: 0 full write, 1 small write, 2 rebuild, 3 reserved |
| cmdLen | input | 16 | Block length in words |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| inValid | input | 1 | All lanes carry a valid word |
| inReady | output | 1 | Lanes consumed this cycle if valid |
| inData | input | 128 | Four 32-bit lanes, lane i at bits 32*i upward |
| outValid | output | 1 | Result word valid |
| outReady | input | 1 | Downstream accepts result word |
| outData | output | 32 | Result word |
| outLast | output | 1 | Final word of the block |
| layoutStripe | input | 16 | Stripe number for the placement lookup |
| layoutIndex | input | 2 | Data block index within the stripe |
| parityMember | output | 3 | Member holding parity for the stripe |
| dataMember | output | 3 | Member holding the indexed data block |

## Verification
On every cycle, the assertions check that results hold under backpressure, that ready never appears outside an operation, and that done follows a final-word handshake and clears busy. They also check that the placement lookup never puts a data block on the parity member and stays within the member range. The bench scenarios alone show the XOR contents for each operation and that lane 3 is left out of small writes. They also show exact word counts and last-flag placement with random stalls on both sides, that commands arriving mid-operation or with reserved codes are ignored, and the placement formula across several rotation periods.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    OP_FULL    = 2'd0,
    OP_SMALL   = 2'd1,
    OP_REBUILD = 2'd2,
    OP_RSVD    = 2'd3
  } op_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture operation code
    logic take;      // consume one word from every lane
    logic takeLast;  // the consumed word is the final one
    logic pop;       // result word accepted downstream
  } strobe_t;
endpackage

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import pe_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  op_t              cmdOp,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             inValid,
  input  logic             outValid,
  input  logic             outReady,
  input  logic             outLast,
  output strobe_t          strb,
  output logic             inReady,
  output logic             busy,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_DONE} state_t;

  state_t           state;
  logic [LEN_W-1:0] remain;
  logic             accept;
  logic             slotFree;

  assign accept   = (state == S_IDLE) && cmdValid && (cmdOp != OP_RSVD) && (cmdLen != '0);
  assign slotFree = !outValid || outReady;
  assign inReady  = (state == S_RUN) && slotFree;

  always_comb begin
    strb          = '0;
    strb.load     = accept;
    strb.take     = inReady && inValid;
    strb.takeLast = strb.take && (remain == LEN_W'(1));
    strb.pop      = outValid && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      remain <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          state  <= S_RUN;
          remain <= cmdLen;
        end
        S_RUN: if (strb.take) begin
          remain <= remain - LEN_W'(1);
          if (strb.takeLast) state <= S_DRAIN;
        end
        S_DRAIN: if (strb.pop && outLast) state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
endmodule

// File: rtl/pe_datapath.sv
module pe_datapath
  import pe_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strb,
  input  op_t          cmdOp,
  input  logic [N*W-1:0] inData,
  output logic         outValid,
  output logic [W-1:0] outData,
  output logic         outLast
);
  localparam int SMALL_LANES = 3;  // new data, old data, old parity

  op_t          opReg;
  logic [N-1:0] laneUse;
  logic [W-1:0] acc;

  generate
    for (genvar i = 0; i < N; i++) begin : g_lane
      if (i < SMALL_LANES) begin : g_always
        assign laneUse[i] = 1'b1;
      end else begin : g_wide
        assign laneUse[i] = (opReg != OP_SMALL);
      end
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++)
      if (laneUse[i]) acc = acc ^ inData[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg    <= OP_FULL;
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
    end else begin
      if (strb.load) opReg <= cmdOp;
      if (strb.take) begin
        outValid <= 1'b1;
        outData  <= acc;
        outLast  <= strb.takeLast;
      end else if (strb.pop) begin
        outValid <= 1'b0;
        outLast  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pe_layout.sv
module pe_layout #(
  parameter int N        = 4,
  parameter int STRIPE_W = 16,
  parameter int MEM_W    = 3,
  parameter int IDX_W    = 2
) (
  input  logic [STRIPE_W-1:0] stripe,
  input  logic [IDX_W-1:0]    index,
  output logic [MEM_W-1:0]    parityMember,
  output logic [MEM_W-1:0]    dataMember
);
  localparam logic [STRIPE_W-1:0] MEMBERS = STRIPE_W'(N + 1);

  logic [STRIPE_W-1:0] rem;
  logic [MEM_W-1:0]    idxWide;

  assign rem          = stripe % MEMBERS;
  assign parityMember = MEM_W'(N) - MEM_W'(rem);
  assign idxWide      = MEM_W'(index);
  assign dataMember   = (idxWide < parityMember) ? idxWide : idxWide + MEM_W'(1);
endmodule

// File: rtl/parity_engine.sv
module parity_engine
  import pe_pkg::*;
#(
  parameter int N        = 4,
  parameter int W        = 32,
  parameter int LEN_W    = 16,
  parameter int STRIPE_W = 16,
  parameter int MEM_W    = $clog2(N + 1),
  parameter int IDX_W    = $clog2(N)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [1:0]          cmdOp,
  input  logic [LEN_W-1:0]    cmdLen,
  output logic                busy,
  output logic                done,
  input  logic                inValid,
  output logic                inReady,
  input  logic [N*W-1:0]      inData,
  output logic                outValid,
  input  logic                outReady,
  output logic [W-1:0]        outData,
  output logic                outLast,
  input  logic [STRIPE_W-1:0] layoutStripe,
  input  logic [IDX_W-1:0]    layoutIndex,
  output logic [MEM_W-1:0]    parityMember,
  output logic [MEM_W-1:0]    dataMember
);
  strobe_t strb;
  op_t     opIn;

  assign opIn = op_t'(cmdOp);

  pe_ctrl #(.LEN_W(LEN_W)) ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(opIn), .cmdLen(cmdLen),
    .inValid(inValid), .outValid(outValid), .outReady(outReady), .outLast(outLast),
    .strb(strb), .inReady(inReady), .busy(busy), .done(done)
  );

  pe_datapath #(.N(N), .W(W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdOp(opIn), .inData(inData),
    .outValid(outValid), .outData(outData), .outLast(outLast)
  );

  pe_layout #(.N(N), .STRIPE_W(STRIPE_W), .MEM_W(MEM_W), .IDX_W(IDX_W)) layout (
    .stripe(layoutStripe), .index(layoutIndex),
    .parityMember(parityMember), .dataMember(dataMember)
  );
endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
  parameter int N     = 4,
  parameter int W     = 32,
  parameter int MEM_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [W-1:0]     outData,
  input logic             outLast,
  input logic [MEM_W-1:0] parityMember,
  input logic [MEM_W-1:0] dataMember
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  assert_ready_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> busy);

  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(outValid && outReady && outLast));

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy);

  assert_parity_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    parityMember <= MEM_W'(N));

  assert_data_apart_R11: assert property (@(posedge clk) disable iff (!rstN)
    dataMember != parityMember);
endmodule

bind parity_engine pe_checker #(.N(N), .W(W), .MEM_W(MEM_W)) chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast),
  .parityMember(parityMember), .dataMember(dataMember)
);

// File: tb/parity_engine_test.sv
`timescale 1ns/1ps
module parity_engine_test;
  logic         clk = 1'b0;
  logic         rstN;
  logic         cmdValid;
  logic [1:0]   cmdOp;
  logic [15:0]  cmdLen;
  logic         busy, done;
  logic         inValid, inReady;
  logic [127:0] inData;
  logic         outValid, outReady, outLast;
  logic [31:0]  outData;
  logic [15:0]  layoutStripe;
  logic [1:0]   layoutIndex;
  logic [2:0]   parityMember, dataMember;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  parity_engine uut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expWord(input int op, input logic [127:0] d);
    logic [31:0] r = '0;
    int lanes = (op == 1) ? 3 : 4;
    for (int i = 0; i < lanes; i++) r = r ^ d[i*32 +: 32];
    return r;
  endfunction

  task automatic runOp(input int op, input int len, input bit inject);
    int taken = 0;
    int got = 0;
    bit lastSeen = 0;
    bit finished = 0;
    bit holdPend = 0;
    logic [31:0] holdData = '0;
    logic [31:0] qd[$];
    bit ql[$];
    string tag = (op == 0) ? "R1" : (op == 1) ? "R2" : "R3";
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdLen = 16'(len);
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy === 1'b1, "R7 busy after accept", longint'(busy), 1);
    for (int cyc = 1; cyc < 4000 && !finished; cyc++) begin
      cmdValid = 1'b0;
      if (lastSeen) begin
        check(done === 1'b1, "R7 done after last", longint'(done), 1);
        finished = 1;
        inValid = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R7 idle after done", longint'({done, busy}), 0);
      end else begin
        check(done === 1'b0, "R7 no early done", longint'(done), 0);
        if (holdPend) begin
          check(outValid === 1'b1 && outData === holdData, "R5 hold", longint'(outData), longint'(holdData));
          holdPend = 0;
        end
        inValid  = ($urandom % 10) < 7;
        outReady = ($urandom % 10) < 7;
        inData   = {$urandom, $urandom, $urandom, $urandom};
        if (inject && cyc == 3) begin
          cmdValid = 1'b1; cmdOp = 2'((op + 1) % 3); cmdLen = 16'd1;
        end
        #1;
        if (inValid && inReady) begin
          qd.push_back(expWord(op, inData));
          ql.push_back(taken == len - 1);
          taken++;
        end
        if (outValid && outReady) begin
          if (qd.size() == 0) begin
            check(0, "R4 unexpected word", longint'(outData), 0);
          end else begin
            check(outData === qd[0], tag, longint'(outData), longint'(qd[0]));
            check(outLast === ql[0], "R6 last flag", longint'(outLast), longint'(ql[0]));
            void'(qd.pop_front());
            void'(ql.pop_front());
          end
          if (outLast) lastSeen = 1;
          got++;
        end else if (outValid) begin
          holdPend = 1;
          holdData = outData;
        end
        @(negedge clk);
      end
    end
    cmdValid = 1'b0;
    check(finished, "R7 operation completes", longint'(finished), 1);
    check(taken == len, "R4 words taken", taken, len);
    check(got == len, "R8 result count unchanged by extra command", got, len);
  endtask

  task automatic ignoredCmd(input int op, input int len, input string req);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdLen = 16'(len);
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy === 1'b0, req, longint'(busy), 0);
    @(negedge clk);
    check(busy === 1'b0 && outValid === 1'b0 && inReady === 1'b0, req, longint'({busy, outValid, inReady}), 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = '0; cmdLen = '0;
    inValid = 1'b0; inData = '0; outReady = 1'b0;
    layoutStripe = '0; layoutIndex = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 0 && done === 0 && outValid === 0 && inReady === 0, "R12 reset state",
          longint'({busy, done, outValid, inReady}), 0);

    // directed corner cases
    runOp(0, 1, 0);            // R1 single word
    runOp(1, 1, 1);            // R2 with command injected while busy (R8)
    runOp(2, 5, 1);            // R3 rebuild, R8
    runOp(1, 7, 0);            // R2 lane 3 random junk
    ignoredCmd(3, 4, "R9 reserved op ignored");
    ignoredCmd(0, 0, "R9 zero length ignored");

    // random mix
    for (int k = 0; k < 20; k++)
      runOp(int'($urandom % 3), 1 + int'($urandom % 12), ($urandom % 2) == 1);

    // placement lookup
    for (int s = 0; s < 25; s++) begin
      for (int d = 0; d < 4; d++) begin
        int pm, dm;
        @(negedge clk);
        layoutStripe = 16'(s); layoutIndex = 2'(d);
        #1;
        pm = 4 - (s % 5);
        dm = (d < pm) ? d : d + 1;
        check(parityMember == 3'(pm), "R10 parity member", longint'(parityMember), pm);
        check(dataMember == 3'(dm), "R11 data member", longint'(dataMember), dm);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule